// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block buffers 24-bit audio words between a register port on the system bus and a serial frame engine. It runs in one of two directions. In playback, software writes words through the data register and the frame engine drains them. In capture, the frame engine fills the buffer and software reads the words back through the same data register. The word storage is sized for the largest size code the instance supports. The size code picks the capacity in use, and the configured channel count decides how much of that capacity a run of frames may occupy.

The channel count is rounded up to a power of two when the depth is derived. Three channels therefore use four-channel units, and five to seven channels use eight-channel units, so some storage stays idle. Status reports the fill level in whole frames. It also holds sticky error flags for a write into a full buffer and for a read from an empty one. An optional level interrupt tells software when the buffer has crossed its halfway point in the direction that needs service. The size code, channel count and direction are static configuration. They change only while the buffer is empty.

Register map, selected by `bus_addr`: 0 is control, 1 is status and 2 is data. A bus read returns its value on `bus_rdata` in the cycle after `bus_rd`, together with `bus_rvalid`.

Top module: `afs_sample_fifo`

## Requirements
- R1: Total capacity is 256 << size code words. A size code above the parameter SIZE_MAX (default 1) is treated as SIZE_MAX.
- R2: The depth in frames is the capacity shifted right by ceil(log2(channels)). The usable word limit is that depth times the channel count, for example 192 words for 3 channels and 160 words for 5 channels at size code 0.
- R3: Status bits [17:8] (10 bits with the default SIZE_MAX) report the number of complete frames held, which is floor(words / channels).
- R4: Only bits [23:0] of a written word are stored. Words leave in the order they entered, and bus data reads return zero in bits [31:24].
- R5: A push into a full buffer is dropped and sets the sticky overrun flag at status bit 4.
- R6: A pop from an empty buffer returns zero and sets the sticky underrun flag at status bit 0.
- R7: A status write clears each flag whose bit is written 0 and leaves a flag whose bit is written 1, so writing zero clears both.
- R8: Writing 1 to control bit 0 empties the buffer at once. The bit reads back as 0.
- R9: With control bit 20 set in playback, `irq` is high while the frame fill is at or below half the frame depth. With bit 20 clear, `irq` stays low.
- R10: With control bit 20 set in capture, `irq` is high while the frame fill is at or above half the frame depth.
- R11: In playback, bus writes to the data register push and `ser_pop` pops, and `ser_push` is ignored. In capture, `ser_push` pushes and bus data reads pop, and bus data writes are ignored.
- R12: After reset the buffer is empty, both flags and the interrupt enable are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 3 | Capacity size code |
| cfg_chans | input | 4 | Channels per frame, 1 to 8 |
| cfg_capture | input | 1 | 1 for capture, 0 for playback |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ser_push | input | 1 | Frame engine push strobe (capture) |
| ser_wdata | input | 24 | Frame engine push word |
| ser_pop | input | 1 | Frame engine pop strobe (playback) |
| ser_rdata | output | 24 | Popped word for the frame engine |
| ser_rvalid | output | 1 | ser_rdata valid, one cycle after ser_pop |
| irq | output | 1 | Half-level interrupt request |

## Verification
If the word or frame counters drift, the status fill field is wrong on the next status read, and the overrun flag rises one entry early or late when the buffer is filled to its limit. A wrong read pointer or a wrong memory index shows up on the very next popped word as a value out of order. A bad remainder count makes the frame field lag or lead the word count by one frame part-way through a frame. The interrupt is a level that follows the fill with one register of delay. A wrong threshold therefore shows within two cycles of the fill crossing half the depth.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int WORD_W     = 24;
  localparam int BASE_WORDS = 256;
  localparam int CHAN_W     = 4;
  localparam int CTL_CLR    = 0;
  localparam int CTL_HALF   = 20;
  localparam int ST_UND     = 0;
  localparam int ST_OVR     = 4;
  localparam int ST_FILL    = 8;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // channels rounded up to a power of two, returned as its log2
  function automatic logic [1:0] chan_log2_up(input logic [CHAN_W-1:0] c);
    if (c <= 4'd1)      return 2'd0;
    else if (c == 4'd2) return 2'd1;
    else if (c <= 4'd4) return 2'd2;
    else                return 2'd3;
  endfunction
endpackage

// File: rtl/afs_geometry.sv
module afs_geometry
  import afs_pkg::*;
#(
  parameter int SIZE_MAX = 1,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic [2:0]        size_code,
  input  logic [CHAN_W-1:0] chans,
  output logic [CNT_W-1:0]  limit_words,
  output logic [CNT_W-1:0]  half_frames,
  output logic [CHAN_W-1:0] chan_eff
);
  localparam logic [2:0] SZ_CAP = 3'(SIZE_MAX);
  localparam int         PW     = CNT_W + CHAN_W;

  logic [2:0]        sz;
  logic [CHAN_W-1:0] ch;
  logic [CNT_W-1:0]  cap, depth;
  logic [PW-1:0]     prod;

  always_comb begin
    sz    = (size_code > SZ_CAP) ? SZ_CAP : size_code;
    if (chans == '0)      ch = 4'd1;
    else if (chans > 4'd8) ch = 4'd8;
    else                   ch = chans;
    cap   = CNT_W'(BASE_WORDS) << sz;
    depth = cap >> chan_log2_up(ch);
    prod  = PW'(depth) * PW'(ch);
  end

  // configuration is static; registering it keeps the multiply off the flag paths
  always_ff @(posedge clk) begin
    limit_words <= prod[CNT_W-1:0];
    half_frames <= depth >> 1;
    chan_eff    <= ch;
  end
endmodule

// File: rtl/afs_store.sv
module afs_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/afs_level.sv
module afs_level
  import afs_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [CHAN_W-1:0] chan_eff,
  input  logic [CNT_W-1:0]  limit_words,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              full,
  output logic              empty,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic [CNT_W-1:0]  words,
  output logic [CNT_W-1:0]  frames,
  output logic [CHAN_W-1:0] rem
);
  always_comb begin
    full    = (words >= limit_words);
    empty   = (words == '0);
    push_ok = push_req && !full && !clr;
    pop_ok  = pop_req && !empty && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      words  <= '0;
      frames <= '0;
      rem    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10: begin
          words <= words + 1'b1;
          if (rem + 4'd1 == chan_eff) begin
            rem    <= '0;
            frames <= frames + 1'b1;
          end else begin
            rem <= rem + 4'd1;
          end
        end
        2'b01: begin
          words <= words - 1'b1;
          if (rem == '0) begin
            rem    <= chan_eff - 4'd1;
            frames <= frames - 1'b1;
          end else begin
            rem <= rem - 4'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/afs_sample_fifo.sv
module afs_sample_fifo
  import afs_pkg::*;
#(
  parameter int SIZE_MAX = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cfg_size,
  input  logic [3:0]  cfg_chans,
  input  logic        cfg_capture,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        ser_push,
  input  logic [23:0] ser_wdata,
  input  logic        ser_pop,
  output logic [23:0] ser_rdata,
  output logic        ser_rvalid,
  output logic        irq
);
  localparam int PHYS  = BASE_WORDS << SIZE_MAX;
  localparam int AW    = $clog2(PHYS);
  localparam int CNT_W = AW + 1;

  logic [CNT_W-1:0]  limit_words, half_frames, words, frames;
  logic [CHAN_W-1:0] chan_eff, rem;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_req, pop_req, push_ok, pop_ok, full, empty, clr;
  logic              wr_data, rd_data, ctl_wr, stat_wr;
  logic [WORD_W-1:0] push_word, mem_q, out_word;
  logic              half_en, ovr, und, zero_q, irq_q, rvalid_q, svalid_q;
  logic [1:0]        rsel_q;
  logic [31:0]       stat_word;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[31:24];

  always_comb begin
    wr_data   = bus_wr && (bus_addr == RA_DATA);
    rd_data   = bus_rd && (bus_addr == RA_DATA);
    ctl_wr    = bus_wr && (bus_addr == RA_CTRL);
    stat_wr   = bus_wr && (bus_addr == RA_STAT);
    clr       = ctl_wr && bus_wdata[CTL_CLR];
    push_req  = cfg_capture ? ser_push : wr_data;
    pop_req   = cfg_capture ? rd_data  : ser_pop;
    push_word = cfg_capture ? ser_wdata : bus_wdata[WORD_W-1:0];
  end

  afs_geometry #(.SIZE_MAX(SIZE_MAX), .CNT_W(CNT_W)) geom_i (
    .clk(clk), .size_code(cfg_size), .chans(cfg_chans),
    .limit_words(limit_words), .half_frames(half_frames), .chan_eff(chan_eff)
  );

  afs_level #(.CNT_W(CNT_W), .AW(AW)) level_i (
    .clk(clk), .rst(rst), .clr(clr), .push_req(push_req), .pop_req(pop_req),
    .chan_eff(chan_eff), .limit_words(limit_words),
    .push_ok(push_ok), .pop_ok(pop_ok), .full(full), .empty(empty),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .words(words), .frames(frames), .rem(rem)
  );

  afs_store #(.DEPTH(PHYS), .AW(AW), .DW(WORD_W)) store_i (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(push_word),
    .re(pop_ok), .raddr(rd_ptr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      half_en  <= 1'b0;
      ovr      <= 1'b0;
      und      <= 1'b0;
      zero_q   <= 1'b0;
      irq_q    <= 1'b0;
      rvalid_q <= 1'b0;
      svalid_q <= 1'b0;
      rsel_q   <= RA_NONE;
    end else begin
      if (ctl_wr) half_en <= bus_wdata[CTL_HALF];
      // a new error in the same cycle wins over a clearing write
      ovr <= (push_req && full) | (ovr & ~(stat_wr & ~bus_wdata[ST_OVR]));
      und <= (pop_req && empty) | (und & ~(stat_wr & ~bus_wdata[ST_UND]));
      if (pop_req) zero_q <= empty;
      irq_q    <= half_en && (cfg_capture ? (frames >= half_frames)
                                          : (frames <= half_frames));
      rvalid_q <= bus_rd;
      svalid_q <= ser_pop && !cfg_capture;
      if (bus_rd) rsel_q <= bus_addr;
    end
  end

  always_comb begin
    out_word = zero_q ? '0 : mem_q;
    stat_word = '0;
    stat_word[ST_FILL +: CNT_W] = frames;
    stat_word[ST_OVR] = ovr;
    stat_word[ST_UND] = und;
    case (rsel_q)
      RA_CTRL: bus_rdata = 32'(half_en) << CTL_HALF;
      RA_STAT: bus_rdata = stat_word;
      RA_DATA: bus_rdata = {8'h00, out_word};
      default: bus_rdata = '0;
    endcase
  end

  assign bus_rvalid = rvalid_q;
  assign ser_rdata  = out_word;
  assign ser_rvalid = svalid_q;
  assign irq        = irq_q;
endmodule

// File: rtl/afs_sample_fifo_chk.sv
module afs_sample_fifo_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             push_req,
  input logic             pop_req,
  input logic             full,
  input logic             empty,
  input logic             clr,
  input logic [CNT_W-1:0] words,
  input logic [CNT_W-1:0] frames,
  input logic [3:0]       rem,
  input logic [3:0]       chan_eff,
  input logic [CNT_W-1:0] limit_words,
  input logic             ovr,
  input logic             und,
  input logic             half_en,
  input logic             irq,
  input logic [23:0]      out_word
);
  localparam int PW = CNT_W + 4;

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
    words <= limit_words);

  a_r3_frames_match_words: assert property (@(posedge clk) disable iff (rst)
    PW'(frames) * PW'(chan_eff) + PW'(rem) == PW'(words));

  a_r5_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    push_req && full |=> ovr);

  a_r6_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    pop_req && empty |=> und && (out_word == 24'd0));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (words == '0));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(half_en));
endmodule

bind afs_sample_fifo afs_sample_fifo_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .full(full), .empty(empty), .clr(clr), .words(words), .frames(frames),
  .rem(rem), .chan_eff(chan_eff), .limit_words(limit_words),
  .ovr(ovr), .und(und), .half_en(half_en), .irq(irq), .out_word(out_word)
);

// File: tb/afs_sample_fifo_tb_top.sv
module afs_sample_fifo_tb_top;
  localparam int FILL_W = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  cfg_size = 3'd0;
  logic [3:0]  cfg_chans = 4'd1;
  logic        cfg_capture = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        ser_push = 1'b0, ser_pop = 1'b0;
  logic [23:0] ser_wdata = '0;
  logic [23:0] ser_rdata;
  logic        ser_rvalid;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [23:0] sb_q[$];
  logic        rd_was_data = 1'b0;
  logic [23:0] got, exp_w;

  afs_sample_fifo dut_i (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_chans(cfg_chans),
    .cfg_capture(cfg_capture), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ser_push(ser_push), .ser_wdata(ser_wdata),
    .ser_pop(ser_pop), .ser_rdata(ser_rdata), .ser_rvalid(ser_rvalid), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: every popped word is compared against the scoreboard head (R4)
  always @(posedge clk) rd_was_data <= bus_rd && (bus_addr == 2'd2) && cfg_capture;

  always @(negedge clk) begin
    if (!rst && (ser_rvalid || (bus_rvalid && rd_was_data))) begin
      got = ser_rvalid ? ser_rdata : bus_rdata[23:0];
      if (!ser_rvalid) chk(bus_rdata[31:24] == 8'h00, "R4 upper bits", bus_rdata, {8'h00, got});
      if (sb_q.size() == 0) chk(1'b0, "R4 unexpected pop", 32'(got), 32'h0);
      else begin
        exp_w = sb_q.pop_front();
        chk(got == exp_w, "R4 word order", 32'(got), 32'(exp_w));
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic read_fill(output int f);
    logic [31:0] v;
    bus_read(2'd1, v);
    f = int'(v[8 +: FILL_W]);
  endtask

  task automatic play_push(input logic [31:0] w, input bit accept);
    if (accept) sb_q.push_back(w[23:0]);
    bus_write(2'd2, w);
  endtask

  task automatic play_pop;
    @(negedge clk); ser_pop = 1'b1;
    @(negedge clk); ser_pop = 1'b0;
  endtask

  task automatic cap_push(input logic [23:0] w, input bit accept);
    if (accept) sb_q.push_back(w);
    @(negedge clk); ser_push = 1'b1; ser_wdata = w;
    @(negedge clk); ser_push = 1'b0;
  endtask

  task automatic cap_pop;
    logic [31:0] v;
    bus_read(2'd2, v);
  endtask

  task automatic setup(input logic [2:0] sz, input logic [3:0] ch, input logic cap);
    bus_write(2'd0, 32'h1);
    sb_q.delete();
    @(negedge clk); cfg_size = sz; cfg_chans = ch; cfg_capture = cap;
    repeat (3) @(negedge clk);
    bus_write(2'd1, 32'h0);
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return {8'hC3, 24'(i * 7919 + salt)};
  endfunction

  initial begin
    #600000;
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int f;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R12 reset state
    bus_read(2'd1, v); chk(v == 32'h0, "R12 status after reset", v, 32'h0);
    bus_read(2'd0, v); chk(v == 32'h0, "R12 control after reset", v, 32'h0);
    chk(irq == 1'b0, "R12 irq after reset", 32'(irq), 32'h0);

    // playback, 2 channels: masking, order, frame count, ignored serial push
    setup(3'd0, 4'd2, 1'b0);
    for (int i = 0; i < 5; i++) play_push(pat(i, 17), 1'b1);
    read_fill(f); chk(f == 2, "R3 frames for 5 words / 2 ch", f, 2);
    @(negedge clk); ser_push = 1'b1; ser_wdata = 24'h123456;
    @(negedge clk); ser_push = 1'b0;
    read_fill(f); chk(f == 2, "R11 ser_push ignored in playback", f, 2);
    for (int i = 0; i < 5; i++) play_pop();
    read_fill(f); chk(f == 0, "R3 empty after drain", f, 0);

    // 3 channels use 4-channel units: 192 words usable
    setup(3'd0, 4'd3, 1'b0);
    for (int i = 0; i < 192; i++) play_push(pat(i, 3), 1'b1);
    bus_read(2'd1, v);
    chk(v[4] == 1'b0, "R2 no overrun at 192 words", v, 32'h0);
    chk(int'(v[8 +: FILL_W]) == 64, "R2 64 frames for 3 ch", v[8 +: FILL_W], 64);
    play_push(pat(999, 3), 1'b0);
    bus_read(2'd1, v);
    chk(v[4] == 1'b1, "R5 overrun flag", v, 32'h10);
    chk(int'(v[8 +: FILL_W]) == 64, "R5 dropped word not stored", v[8 +: FILL_W], 64);
    for (int i = 0; i < 192; i++) play_pop();
    sb_q.push_back(24'h0);
    play_pop();
    bus_read(2'd1, v);
    chk(v[0] == 1'b1, "R6 underrun flag", v, 32'h11);

    // R7 selective flag clear
    bus_write(2'd1, 32'h10);
    bus_read(2'd1, v); chk(v[4:0] == 5'h10, "R7 keep ovr, clear und", v, 32'h10);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, v); chk(v[4:0] == 5'h00, "R7 write zero clears both", v, 32'h0);

    // R8 clear
    for (int i = 0; i < 10; i++) play_push(pat(i, 55), 1'b1);
    read_fill(f); chk(f == 3, "R3 frames for 10 words / 3 ch", f, 3);
    bus_write(2'd0, 32'h1);
    sb_q.delete();
    read_fill(f); chk(f == 0, "R8 clear empties", f, 0);
    bus_read(2'd0, v); chk(v[0] == 1'b0, "R8 clear bit self-clears", v, 32'h0);
    for (int i = 0; i < 2; i++) play_push(pat(i, 77), 1'b1);
    for (int i = 0; i < 2; i++) play_pop();

    // 5 channels: 32 frames, 160 words
    setup(3'd0, 4'd5, 1'b0);
    for (int i = 0; i < 160; i++) play_push(pat(i, 9), 1'b1);
    bus_read(2'd1, v); chk(v[4] == 1'b0, "R2 no overrun at 160 words", v, 32'h0);
    play_push(pat(0, 9), 1'b0);
    bus_read(2'd1, v); chk(v[4] == 1'b1, "R2 overrun past 160 words", v, 32'h10);

    // R1 size code 1 and clamped size code 6 both give 512 words
    for (int s = 0; s < 2; s++) begin
      setup((s == 0) ? 3'd1 : 3'd6, 4'd1, 1'b0);
      for (int i = 0; i < 512; i++) play_push(pat(i, s), 1'b1);
      bus_read(2'd1, v);
      chk(v[4] == 1'b0 && int'(v[8 +: FILL_W]) == 512, "R1 512 words fit", v, 32'h20000);
      play_push(pat(0, s), 1'b0);
      bus_read(2'd1, v);
      chk(v[4] == 1'b1, "R1 overrun at 513th word", v, 32'h20010);
    end

    // R9 playback half interrupt, 1 channel, 256 frames, half 128
    setup(3'd0, 4'd1, 1'b0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 irq low when disabled", 32'(irq), 32'h0);
    bus_write(2'd0, 32'h0010_0000);
    bus_read(2'd0, v); chk(v == 32'h0010_0000, "R9 enable readback", v, 32'h0010_0000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq when empty", 32'(irq), 32'h1);
    for (int i = 0; i < 128; i++) play_push(pat(i, 1), 1'b1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq at exactly half", 32'(irq), 32'h1);
    play_push(pat(128, 1), 1'b1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 irq low above half", 32'(irq), 32'h0);
    play_pop();
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq back at half", 32'(irq), 32'h1);

    // R10 capture half interrupt and R11 routing
    setup(3'd0, 4'd1, 1'b1);
    bus_write(2'd0, 32'h0010_0000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq low when empty", 32'(irq), 32'h0);
    for (int i = 0; i < 127; i++) cap_push(pat(i, 5)[23:0], 1'b1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq low below half", 32'(irq), 32'h0);
    cap_push(24'hABCDEF, 1'b1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R10 irq at half", 32'(irq), 32'h1);
    bus_write(2'd2, 32'h0055_AA55);
    read_fill(f); chk(f == 128, "R11 bus data write ignored in capture", f, 128);
    for (int i = 0; i < 3; i++) cap_pop();
    read_fill(f); chk(f == 125, "R11 bus reads pop in capture", f, 125);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq drops below half", 32'(irq), 32'h0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule